// File: doc/BRIEF.md
# Multicycle Integer Core

A 32-bit processor that executes a small integer instruction subset one step per clock, reusing a single adder/logic unit and a single memory port for every step. Each instruction is fetched into an instruction latch, its source registers are copied into two operand latches, and the result travels through a result latch (and, for loads, a memory data latch) before it reaches the register file. Because no step is shared with the next instruction, each instruction class finishes in its own number of cycles.

The core drives one word-wide memory port with address, write data and a write strobe, and it samples read data within the same cycle. Instruction fetch and data access take turns on this port: the address is the program counter except in the cycles that read or write data. A program is placed in that memory, and the core runs from the reset address onward.

Top module: `mc_core`

## Requirements
- R1: An active-low asynchronous reset sets the program counter to RST_PC (default 0), clears all 32 general registers and enters the fetch step; while reset is low the memory address equals RST_PC and the write strobe is 0.
- R2: In the fetch step the memory address is the program counter, the word read is latched as the instruction, and the program counter advances by 4 at the closing edge.
- R3: Opcode 0 selects a register-register operation by bits [5:0]: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x00 shift left, 0x02 shift right logical; sources are bits [25:21] and [20:16], the destination is bits [15:11], and shifts move the [20:16] register by bits [10:6].
- R4: Opcodes 0x08 (add, immediate sign-extended), 0x0C (and, immediate zero-extended) and 0x0D (or, immediate zero-extended) combine register [25:21] with the 16-bit immediate in [15:0] and write register [20:16].
- R5: Opcode 0x23 loads the word at register [25:21] plus the sign-extended immediate into register [20:16].
- R6: Opcode 0x2B stores register [20:16] at register [25:21] plus the sign-extended immediate; the write strobe is high for exactly one cycle, with that address and data.
- R7: Opcode 0x04 branches when the two source registers are equal and 0x05 when they differ; the target is the instruction address plus 4 plus 4 times the sign-extended immediate, otherwise execution falls through.
- R8: Opcode 0x02 jumps to the upper 4 bits of the next-instruction address followed by bits [25:0] and two zero bits; opcode 0x03 does the same and also writes the instruction address plus 4 into register 31.
- R9: Register 0 always reads as zero; writes to it have no effect.
- R10: Cycle counts are 4 for register and immediate arithmetic, 5 for loads, 4 for stores and 3 for branches and jumps, counting from the fetch step to the next fetch step.
- R11: The memory address equals the result latch only in the data read and data write steps; in every other step it equals the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Byte address for fetch or data access |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Store strobe |
| mem_rdata_i | input | 32 | Read data, valid in the same cycle |

## Verification
The bench builds the core with its default parameters: a reset address of 0, a 32-bit word and 32 registers. With the reset address at 0, a small word-indexed memory holds every program and every data word, so the jump targets, the link value written by the jump-and-link and the branch targets are all plain small numbers the bench derives by hand. One long program reaches all arithmetic, shift, extension and control-flow cases and leaves its results in memory; short programs started from reset time each instruction class by counting edges up to the first store strobe.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NREG   = 32;
  localparam int unsigned RIDX_W = $clog2(NREG);
  localparam int unsigned SH_W   = $clog2(XLEN);
  localparam int unsigned OP_W   = 6;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned TGT_W  = 26;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_J     = 6'h02;
  localparam logic [OP_W-1:0] OP_JAL   = 6'h03;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_BNE   = 6'h05;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'h0C;
  localparam logic [OP_W-1:0] OP_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OP_LW    = 6'h23;
  localparam logic [OP_W-1:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EXEC_R, S_EXEC_I, S_ADDR,
    S_MEM_RD, S_MEM_WR, S_WB_ALU, S_WB_LD, S_BRANCH, S_JUMP
  } state_e;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLL, ALU_SRL} alu_op_e;
  typedef enum logic [1:0] {SRC_B_REG, SRC_B_FOUR, SRC_B_IMM, SRC_B_BOFS} src_b_e;
  typedef enum logic [1:0] {WA_RD, WA_RT, WA_LINK} wa_sel_e;
  typedef enum logic [1:0] {WD_ALU, WD_MDR, WD_PC} wd_sel_e;
  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_BR, PC_JMP} pc_sel_e;

  typedef struct packed {
    logic    ir_we;
    pc_sel_e pc_sel;
    logic    ab_we;
    logic    res_we;
    logic    mdr_we;
    logic    rf_we;
    logic    mem_we;
    logic    addr_res;
    logic    src_a_reg;
    src_b_e  src_b;
    alu_op_e alu_op;
    logic    imm_zext;
    logic    br_ne;
    wa_sel_e wa_sel;
    wd_sel_e wd_sel;
  } ctrl_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [SH_W-1:0] shamt_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] res_o,
  output logic            zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLL: res_o = b_i << shamt_i;
      ALU_SRL: res_o = b_i >> shamt_i;
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int unsigned N_REGS = NREG,
  localparam int unsigned IDX_W = $clog2(N_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ra_i,
  input  logic [IDX_W-1:0] rb_i,
  output logic [XLEN-1:0]  rdata_a_o,
  output logic [XLEN-1:0]  rdata_b_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wa_i,
  input  logic [XLEN-1:0]  wd_i
);
  logic [XLEN-1:0] rf_q [N_REGS];

  // entry 0 is hard-wired, never stored
  assign rf_q[0] = '0;

  for (genvar g = 1; g < N_REGS; g++) begin : g_reg
    logic [XLEN-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                r_q <= '0;
      else if (we_i && wa_i == IDX_W'(g))         r_q <= wd_i;
    end
    assign rf_q[g] = r_q;
  end

  assign rdata_a_o = rf_q[ra_i];
  assign rdata_b_o = rf_q[rb_i];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  input  logic [5:0]      funct_i,
  output state_e          state_o,
  output ctrl_t           ctrl_o
);
  state_e state_q, state_d;

  function automatic alu_op_e funct_op(logic [5:0] fn);
    unique case (fn)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_SLL:  return ALU_SLL;
      FN_SRL:  return ALU_SRL;
      default: return ALU_ADD;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = S_FETCH;
    unique case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        unique case (opcode_i)
          OP_RTYPE:                  state_d = S_EXEC_R;
          OP_ADDI, OP_ANDI, OP_ORI:  state_d = S_EXEC_I;
          OP_LW, OP_SW:              state_d = S_ADDR;
          OP_BEQ, OP_BNE:            state_d = S_BRANCH;
          OP_J, OP_JAL:              state_d = S_JUMP;
          default:                   state_d = S_FETCH;
        endcase
      end
      S_EXEC_R, S_EXEC_I: state_d = S_WB_ALU;
      S_ADDR:   state_d = (opcode_i == OP_LW) ? S_MEM_RD : S_MEM_WR;
      S_MEM_RD: state_d = S_WB_LD;
      default:  state_d = S_FETCH;
    endcase
  end

  always_comb begin
    ctrl_o = '0;
    unique case (state_q)
      S_FETCH: begin
        ctrl_o.ir_we  = 1'b1;
        ctrl_o.pc_sel = PC_INC;
        ctrl_o.src_b  = SRC_B_FOUR;
      end
      S_DECODE: begin
        // branch target is formed speculatively while operands are read
        ctrl_o.ab_we  = 1'b1;
        ctrl_o.res_we = 1'b1;
        ctrl_o.src_b  = SRC_B_BOFS;
      end
      S_EXEC_R: begin
        ctrl_o.res_we    = 1'b1;
        ctrl_o.src_a_reg = 1'b1;
        ctrl_o.src_b     = SRC_B_REG;
        ctrl_o.alu_op    = funct_op(funct_i);
      end
      S_EXEC_I: begin
        ctrl_o.res_we    = 1'b1;
        ctrl_o.src_a_reg = 1'b1;
        ctrl_o.src_b     = SRC_B_IMM;
        ctrl_o.imm_zext  = (opcode_i == OP_ANDI) || (opcode_i == OP_ORI);
        ctrl_o.alu_op    = (opcode_i == OP_ANDI) ? ALU_AND :
                           (opcode_i == OP_ORI)  ? ALU_OR  : ALU_ADD;
      end
      S_ADDR: begin
        ctrl_o.res_we    = 1'b1;
        ctrl_o.src_a_reg = 1'b1;
        ctrl_o.src_b     = SRC_B_IMM;
      end
      S_MEM_RD: begin
        ctrl_o.addr_res = 1'b1;
        ctrl_o.mdr_we   = 1'b1;
      end
      S_MEM_WR: begin
        ctrl_o.addr_res = 1'b1;
        ctrl_o.mem_we   = 1'b1;
      end
      S_WB_ALU: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.wa_sel = (opcode_i == OP_RTYPE) ? WA_RD : WA_RT;
        ctrl_o.wd_sel = WD_ALU;
      end
      S_WB_LD: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.wa_sel = WA_RT;
        ctrl_o.wd_sel = WD_MDR;
      end
      S_BRANCH: begin
        ctrl_o.src_a_reg = 1'b1;
        ctrl_o.src_b     = SRC_B_REG;
        ctrl_o.alu_op    = ALU_SUB;
        ctrl_o.pc_sel    = PC_BR;
        ctrl_o.br_ne     = (opcode_i == OP_BNE);
      end
      S_JUMP: begin
        ctrl_o.pc_sel = PC_JMP;
        ctrl_o.rf_we  = (opcode_i == OP_JAL);
        ctrl_o.wa_sel = WA_LINK;
        ctrl_o.wd_sel = WD_PC;
      end
      default: ;
    endcase
  end

  assign state_o = state_q;
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter logic [XLEN-1:0] RST_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_we_o,
  input  logic [XLEN-1:0] mem_rdata_i
);
  localparam int unsigned PAGE_W = XLEN - TGT_W - 2;

  logic [XLEN-1:0] pc_q, ir_q, reg_a_q, reg_b_q, res_q, mdr_q;
  state_e state_q;
  ctrl_t  ctrl;

  logic [OP_W-1:0]   opcode;
  logic [RIDX_W-1:0] rs, rt, rd, wa;
  logic [SH_W-1:0]   shamt;
  logic [IMM_W-1:0]  imm;
  logic [TGT_W-1:0]  target;
  logic [XLEN-1:0]   imm_sx, imm_ext, src_a, src_b, alu_res, rf_a, rf_b, wd;
  logic              alu_zero, br_take;

  assign opcode = ir_q[31:26];
  assign rs     = ir_q[25:21];
  assign rt     = ir_q[20:16];
  assign rd     = ir_q[15:11];
  assign shamt  = ir_q[10:6];
  assign imm    = ir_q[IMM_W-1:0];
  assign target = ir_q[TGT_W-1:0];

  mc_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode),
    .funct_i  (ir_q[5:0]),
    .state_o  (state_q),
    .ctrl_o   (ctrl)
  );

  assign imm_sx  = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_ext = ctrl.imm_zext ? {{(XLEN-IMM_W){1'b0}}, imm} : imm_sx;

  assign src_a = ctrl.src_a_reg ? reg_a_q : pc_q;

  always_comb begin
    unique case (ctrl.src_b)
      SRC_B_REG:  src_b = reg_b_q;
      SRC_B_FOUR: src_b = XLEN'(4);
      SRC_B_IMM:  src_b = imm_ext;
      default:    src_b = imm_sx << 2;
    endcase
  end

  mc_alu i_alu (
    .a_i     (src_a),
    .b_i     (src_b),
    .shamt_i (shamt),
    .op_i    (ctrl.alu_op),
    .res_o   (alu_res),
    .zero_o  (alu_zero)
  );

  always_comb begin
    unique case (ctrl.wa_sel)
      WA_RD:   wa = rd;
      WA_RT:   wa = rt;
      default: wa = RIDX_W'(NREG - 1);
    endcase
  end

  always_comb begin
    unique case (ctrl.wd_sel)
      WD_MDR:  wd = mdr_q;
      WD_PC:   wd = pc_q;
      default: wd = res_q;
    endcase
  end

  mc_regfile #(.N_REGS(NREG)) i_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_i      (rs),
    .rb_i      (rt),
    .rdata_a_o (rf_a),
    .rdata_b_o (rf_b),
    .we_i      (ctrl.rf_we),
    .wa_i      (wa),
    .wd_i      (wd)
  );

  assign br_take = ctrl.br_ne ? !alu_zero : alu_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RST_PC;
      ir_q    <= '0;
      reg_a_q <= '0;
      reg_b_q <= '0;
      res_q   <= '0;
      mdr_q   <= '0;
    end else begin
      unique case (ctrl.pc_sel)
        PC_INC:  pc_q <= alu_res;
        PC_BR:   if (br_take) pc_q <= res_q;
        PC_JMP:  pc_q <= {pc_q[XLEN-1 -: PAGE_W], target, 2'b00};
        default: ;
      endcase
      if (ctrl.ir_we)  ir_q <= mem_rdata_i;
      if (ctrl.ab_we) begin
        reg_a_q <= rf_a;
        reg_b_q <= rf_b;
      end
      if (ctrl.res_we) res_q <= alu_res;
      if (ctrl.mdr_we) mdr_q <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = ctrl.addr_res ? res_q : pc_q;
  assign mem_wdata_o = reg_b_q;
  assign mem_we_o    = ctrl.mem_we;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] mem_addr_i,
  input logic            mem_we_i,
  input state_e          state_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] ir_i,
  input logic [XLEN-1:0] reg_a_i,
  input logic [XLEN-1:0] reg_b_i
);
  a_r2_fetch_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FETCH |=> pc_i == $past(pc_i) + XLEN'(4));

  a_r11_fetch_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FETCH |-> mem_addr_i == pc_i);

  a_r6_store_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i && mem_addr_i == $past(pc_i));

  a_r9_r0_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_DECODE && ir_i[25:21] == '0) |=> reg_a_i == '0);

  a_r7_beq_fallthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_BRANCH && ir_i[31:26] == OP_BEQ && reg_a_i != reg_b_i)
      |=> pc_i == $past(pc_i));

  a_r8_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_JUMP |=> pc_i[27:0] == {$past(ir_i[25:0]), 2'b00}
                          && pc_i[31:28] == $past(pc_i[31:28]));
endmodule

bind mc_core mc_core_chk i_mc_core_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_i (mem_addr_o),
  .mem_we_i   (mem_we_o),
  .state_i    (state_q),
  .pc_i       (pc_q),
  .ir_i       (ir_q),
  .reg_a_i    (reg_a_q),
  .reg_b_i    (reg_b_q)
);

// File: tb/test_mc_core.sv
module test_mc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr, wdata, rdata;
  logic        we;
  logic [31:0] mem [0:255];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mc_core i_mc_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (addr),
    .mem_wdata_o (wdata),
    .mem_we_o    (we),
    .mem_rdata_i (rdata)
  );

  assign rdata = mem[addr[9:2]];
  always @(posedge clk) if (we) mem[addr[9:2]] <= wdata;

  // {requirement, byte address, expected word} left by the long program
  localparam logic [67:0] EXP_TBL [13] = '{
    {4'd3,  32'h200, 32'h0000_0002},
    {4'd3,  32'h204, 32'h0000_0008},
    {4'd4,  32'h208, 32'h0000_F0F0},
    {4'd4,  32'h20C, 32'h0000_8001},
    {4'd3,  32'h210, 32'h0000_8001},
    {4'd3,  32'h214, 32'h0000_8005},
    {4'd3,  32'h218, 32'h0000_0050},
    {4'd3,  32'h21C, 32'h0000_000F},
    {4'd9,  32'h220, 32'h0000_0000},
    {4'd4,  32'h224, 32'hFFFF_FFFD},
    {4'd5,  32'h228, 32'h0000_0008},
    {4'd7,  32'h22C, 32'h0000_0003},
    {4'd8,  32'h230, 32'h0000_0084}
  };

  function automatic string req_name(logic [3:0] k);
    case (k)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [4:0] sh);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] tgt);
    return {op, tgt};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  task automatic load_main();
    clear_mem();
    mem[0]  = enc_i(6'h08, 5'd0, 5'd1, 16'd5);
    mem[1]  = enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD);
    mem[2]  = enc_r(6'h20, 5'd1, 5'd2, 5'd3, 5'd0);
    mem[3]  = enc_r(6'h22, 5'd1, 5'd2, 5'd4, 5'd0);
    mem[4]  = enc_i(6'h0C, 5'd2, 5'd5, 16'hF0F0);
    mem[5]  = enc_i(6'h0D, 5'd0, 5'd6, 16'h8001);
    mem[6]  = enc_r(6'h24, 5'd2, 5'd6, 5'd7, 5'd0);
    mem[7]  = enc_r(6'h25, 5'd1, 5'd6, 5'd8, 5'd0);
    mem[8]  = enc_r(6'h00, 5'd0, 5'd1, 5'd9, 5'd4);
    mem[9]  = enc_r(6'h02, 5'd0, 5'd2, 5'd10, 5'd28);
    mem[10] = enc_i(6'h08, 5'd0, 5'd0, 16'd7);
    mem[11] = enc_i(6'h2B, 5'd0, 5'd3, 16'h200);
    mem[12] = enc_i(6'h2B, 5'd0, 5'd4, 16'h204);
    mem[13] = enc_i(6'h2B, 5'd0, 5'd5, 16'h208);
    mem[14] = enc_i(6'h2B, 5'd0, 5'd6, 16'h20C);
    mem[15] = enc_i(6'h2B, 5'd0, 5'd7, 16'h210);
    mem[16] = enc_i(6'h2B, 5'd0, 5'd8, 16'h214);
    mem[17] = enc_i(6'h2B, 5'd0, 5'd9, 16'h218);
    mem[18] = enc_i(6'h2B, 5'd0, 5'd10, 16'h21C);
    mem[19] = enc_i(6'h2B, 5'd0, 5'd0, 16'h220);
    mem[20] = enc_i(6'h2B, 5'd0, 5'd2, 16'h224);
    mem[21] = enc_i(6'h08, 5'd0, 5'd12, 16'h230);
    mem[22] = enc_i(6'h23, 5'd12, 5'd11, 16'hFFD4);
    mem[23] = enc_i(6'h2B, 5'd0, 5'd11, 16'h228);
    mem[24] = enc_i(6'h04, 5'd1, 5'd2, 16'd1);
    mem[25] = enc_i(6'h08, 5'd0, 5'd13, 16'd1);
    mem[26] = enc_i(6'h04, 5'd1, 5'd1, 16'd1);
    mem[27] = enc_i(6'h08, 5'd0, 5'd13, 16'd99);
    mem[28] = enc_i(6'h05, 5'd1, 5'd2, 16'd1);
    mem[29] = enc_i(6'h08, 5'd0, 5'd13, 16'd77);
    mem[30] = enc_i(6'h05, 5'd1, 5'd1, 16'd1);
    mem[31] = enc_i(6'h08, 5'd13, 5'd13, 16'd2);
    mem[32] = enc_j(6'h03, 26'd40);
    mem[33] = enc_i(6'h08, 5'd0, 5'd13, 16'd55);
    mem[40] = enc_i(6'h2B, 5'd0, 5'd13, 16'h22C);
    mem[41] = enc_i(6'h2B, 5'd0, 5'd31, 16'h230);
    mem[42] = enc_j(6'h02, 26'd45);
    mem[43] = enc_i(6'h08, 5'd0, 5'd13, 16'd66);
    mem[44] = enc_i(6'h2B, 5'd0, 5'd13, 16'h22C);
    mem[45] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
    mem[136] = 32'hDEAD_BEEF; // 0x220: must become 0
  endtask

  task automatic wait_store(output int n);
    n = 0;
    do begin
      @(posedge clk); #2;
      n++;
    end while (!we && n < 64);
  endtask

  // short program from reset; count edges up to the first store strobe
  task automatic run_case(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
                          input int exp_n, input logic [31:0] exp_a, input logic [31:0] exp_d,
                          input string req);
    int n;
    rst_n = 1'b0;
    clear_mem();
    mem[0] = w0;
    mem[1] = w1;
    mem[2] = w2;
    mem[128] = 32'h1234_5678;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait_store(n);
    check(req, "cycles to store", 32'(n), 32'(exp_n));
    check(req, "store address", addr, exp_a);
    check(req, "store data", wdata, exp_d);
  endtask

  initial begin
    load_main();
    repeat (2) @(posedge clk);
    #2;
    check("R1", "addr in reset", addr, 32'h0);
    check("R1", "we in reset", {31'h0, we}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2", "first fetch addr", addr, 32'h0);
    @(posedge clk); #2;
    check("R2", "pc after fetch", addr, 32'h4);

    repeat (300) @(posedge clk);
    #2;
    for (int k = 0; k < 13; k++)
      check(req_name(EXP_TBL[k][67:64]), $sformatf("mem[%h]", EXP_TBL[k][63:32]),
            mem[EXP_TBL[k][41:34]], EXP_TBL[k][31:0]);

    // core now spins at 0xB4; asynchronous reset must act at once (R1)
    @(posedge clk); #3;
    rst_n = 1'b0;
    #1;
    check("R1", "addr after async reset", addr, 32'h0);
    check("R1", "we after async reset", {31'h0, we}, 32'h0);

    // registers cleared by reset: r3 held 2 before (R1), store in 4 cycles (R10)
    run_case(enc_i(6'h2B, 5'd0, 5'd3, 16'h200), 32'h0, 32'h0, 3, 32'h200, 32'h0, "R1 R10 sw");
    @(posedge clk); #2;
    check("R11", "addr back to pc after store", addr, 32'h4);
    check("R6", "store strobe one cycle", {31'h0, we}, 32'h0);

    run_case(enc_i(6'h08, 5'd0, 5'd1, 16'd9), enc_i(6'h2B, 5'd0, 5'd1, 16'h204), 32'h0,
             7, 32'h204, 32'h9, "R10 addi");
    run_case(enc_r(6'h25, 5'd0, 5'd0, 5'd1, 5'd0), enc_i(6'h2B, 5'd0, 5'd1, 16'h208), 32'h0,
             7, 32'h208, 32'h0, "R10 rtype");
    run_case(enc_i(6'h23, 5'd0, 5'd1, 16'h200), enc_i(6'h2B, 5'd0, 5'd1, 16'h204), 32'h0,
             8, 32'h204, 32'h1234_5678, "R5 R6 R10 lw");
    run_case(enc_i(6'h04, 5'd0, 5'd0, 16'd1), 32'h0, enc_i(6'h2B, 5'd0, 5'd0, 16'h20C),
             6, 32'h20C, 32'h0, "R7 R10 beq");
    run_case(enc_i(6'h05, 5'd0, 5'd0, 16'd5), enc_i(6'h2B, 5'd0, 5'd0, 16'h214), 32'h0,
             6, 32'h214, 32'h0, "R7 R10 bne");
    run_case(enc_j(6'h03, 26'd2), 32'h0, enc_i(6'h2B, 5'd0, 5'd31, 16'h210),
             6, 32'h210, 32'h4, "R8 R10 jal");
    run_case(enc_j(6'h02, 26'd2), 32'h0, enc_i(6'h2B, 5'd0, 5'd0, 16'h218),
             6, 32'h218, 32'h0, "R8 R10 j");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule